// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block is the receive side of a slave-only serial audio port. An external source supplies a bit clock, a frame clock and up to three serial data lines. The block runs on a fast system clock that is synchronously derived from the same master clock as the bit and frame clocks. It samples all of these inputs on that system clock, finds the rising bit-clock edges, and decodes one of five framings. It then presents six parallel channel words, together with a one-cycle strobe that marks each complete frame.

Three of the framings are stereo-pair formats: left-justified, I2S and right-justified. In these, each data line carries one left/right pair, and the frame-clock level tells the two halves apart. The other two framings are single-line six-channel modes. In these, a rising frame clock starts a frame of six fixed-width slots on the first data line. A three-bit format code selects the framing. A five-bit word-length input sets how many bits of each slot or half-frame carry the sample. Output slot k (0..5) holds channel A1, B1, A2, B2, A3, B3 in that order. The format and word length are meant to be set while the block is held in reset.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is asserted and right after it, every output channel word reads zero and the frame strobe is low.
- R2: The format code selects the framing. Code 0 is left-justified, 1 is I2S, 2 is right-justified, 3 is one-line and 4 is TDM. Codes 5 to 7 decode exactly as left-justified.
- R3: In left-justified, a high frame clock marks the left half. The sample MSB is the bit sampled on the first rising bit-clock edge that sees the new frame-clock level.
- R4: In I2S, a low frame clock marks the left half, and the MSB is the bit one bit-clock after the frame-clock change.
- R5: In right-justified, a high frame clock marks the left half. The sample is the last word-length bits before the frame-clock change, with its LSB being the final bit of the half.
- R6: In the three stereo formats, data line n (0..2) feeds output slot 2n with its left word and slot 2n+1 with its right word.
- R7: In one-line and TDM, a frame starts at the rising bit-clock edge where the frame clock is first seen high. Six slots of SLOT_W bits then follow on data line 0 and fill outputs 0 to 5 in order. In one-line, a slot's MSB sits on the slot's first bit. In TDM, every slot is delayed by one bit.
- R8: In one-line and TDM, data lines 1 and 2 have no effect on any output.
- R9: The word length is taken as 16 when below 16 and as 24 when above 24. Each received word is placed MSB-aligned in a 24-bit output with zeros in the unused low bits. Samples are two's complement, sent MSB first.
- R10: The frame strobe is high for exactly one system clock after the edge that writes the last of the six channel words of one frame. A frame whose six words were not all written since its first channel produces no strobe.
- R11: Outputs change only at the system clock edge that follows a sampled rising bit-clock edge. Frame-clock or data activity while the bit clock is idle changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, synchronous to the serial clocks |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_i | input | 3 | Framing select code |
| wlen_i | input | 5 | Sample word length in bits |
| bclk_i | input | 1 | Serial bit clock |
| fclk_i | input | 1 | Frame clock at the sample rate |
| sd_i | input | 3 | Serial data lines 0 to 2 |
| smp_o | output | 6 x 24 | Channel words, index k = A1, B1, A2, B2, A3, B3 |
| valid_o | output | 1 | One-cycle frame-complete strobe |

## Verification
A bit counter that is off by one shifts every captured word by one bit position. This shows up as a mismatched channel word at the very first frame strobe. A wrong slot counter or half-frame polarity puts correct words into the wrong output indices, which is also visible at the first strobe. A broken completion mask shows within one frame period: the strobe appears too early, too often, or never, so the number of strobes per run differs from the number of frames sent. Padding and line-ignoring faults corrupt the low bits or single-line words at the first strobe after they occur.

// File: rtl/sarx_pkg.sv
package sarx_pkg;
    localparam int WORD_W  = 24;
    localparam int MIN_W   = 16;
    localparam int LINES   = 3;
    localparam int CHANS   = 2 * LINES;
    localparam int WL_W    = $clog2(WORD_W + 1);
    localparam int SLOT_IW = $clog2(CHANS + 1);

    localparam logic [2:0] FMT_LJ  = 3'd0;
    localparam logic [2:0] FMT_I2S = 3'd1;
    localparam logic [2:0] FMT_RJ  = 3'd2;
    localparam logic [2:0] FMT_ONE = 3'd3;
    localparam logic [2:0] FMT_TDM = 3'd4;

    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/sarx_edge.sv
module sarx_edge
    import sarx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bclk_i,
    input  logic             fclk_i,
    input  logic [LINES-1:0] sd_i,
    output logic             bit_stb_o,
    output logic             fclk_o,
    output logic [LINES-1:0] sd_o
);
    typedef struct packed {
        logic             bclk;
        logic             bclk_prev;
        logic             fclk;
        logic [LINES-1:0] sd;
    } edge_st_t;

    edge_st_t s_d, s_q;

    always_comb begin
        s_d           = s_q;
        s_d.bclk_prev = s_q.bclk;
        s_d.bclk      = bclk_i;
        s_d.fclk      = fclk_i;
        s_d.sd        = sd_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // a rising bit-clock edge: sampled high now, low one cycle before
    assign bit_stb_o = s_q.bclk & ~s_q.bclk_prev;
    assign fclk_o    = s_q.fclk;
    assign sd_o      = s_q.sd;
endmodule

// File: rtl/sarx_shift.sv
module sarx_shift
    import sarx_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_i,
    input  logic            bit_i,
    input  logic            old_i,
    input  logic [WL_W-1:0] wl_i,
    output word_t           word_o
);
    word_t sh_d, sh_q;
    word_t src;

    always_comb begin
        sh_d = sh_q;
        if (en_i) sh_d = {sh_q[WORD_W-2:0], bit_i};
        // right-justified takes the word before the bit that opened the new half
        src    = old_i ? sh_q : sh_d;
        word_o = src << (WORD_W - int'(wl_i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end
endmodule

// File: rtl/sarx_frame.sv
module sarx_frame
    import sarx_pkg::*;
#(
    parameter int SLOT_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       fmt_i,
    input  logic [WL_W-1:0]  wl_i,
    input  logic             bit_stb_i,
    input  logic             fclk_i,
    output logic [CHANS-1:0] cap_o,
    output logic             first_o,
    output logic             single_o,
    output logic             old_o
);
    localparam logic [CNT_W-1:0]   SLOT_LAST = CNT_W'(SLOT_W - 1);
    localparam logic [SLOT_IW-1:0] SLOT_END  = SLOT_IW'(CHANS);

    typedef struct packed {
        logic [CNT_W-1:0]   cnt;
        logic [SLOT_IW-1:0] slot;
        logic               fclk_last;
        logic               synced;
        logic [2:0]         fmt_last;
    } frm_st_t;

    frm_st_t s_d, s_q;

    logic             is_i2s, is_rj, is_tdm, is_single, delayed;
    logic             start, chg, left;
    logic [CNT_W-1:0] tgt;
    logic [CHANS-1:0] left_bits, right_bits;

    always_comb begin
        is_i2s    = (fmt_i == FMT_I2S);
        is_rj     = (fmt_i == FMT_RJ);
        is_tdm    = (fmt_i == FMT_TDM);
        is_single = (fmt_i == FMT_ONE) || is_tdm;
        delayed   = is_i2s || is_tdm;

        for (int i = 0; i < CHANS; i++) begin
            left_bits[i]  = (i % 2) == 0;
            right_bits[i] = (i % 2) == 1;
        end

        tgt = CNT_W'(wl_i);
        if (!delayed) tgt = tgt - CNT_W'(1);

        s_d          = s_q;
        s_d.fmt_last = fmt_i;
        cap_o        = '0;
        first_o      = 1'b0;
        start        = 1'b0;
        chg          = 1'b0;
        left         = 1'b0;

        if (fmt_i != s_q.fmt_last) begin
            s_d.synced = 1'b0;
            s_d.cnt    = '0;
            s_d.slot   = SLOT_END;
        end else if (bit_stb_i) begin
            s_d.fclk_last = fclk_i;
            if (is_single) begin
                start = fclk_i & ~s_q.fclk_last;
                if (start) begin
                    s_d.cnt    = '0;
                    s_d.slot   = '0;
                    s_d.synced = 1'b1;
                end else if (s_q.slot < SLOT_END) begin
                    if (s_q.cnt == SLOT_LAST) begin
                        s_d.cnt  = '0;
                        s_d.slot = s_q.slot + SLOT_IW'(1);
                    end else begin
                        s_d.cnt = s_q.cnt + CNT_W'(1);
                    end
                end
                if ((start || s_q.synced) && (s_d.slot < SLOT_END) && (s_d.cnt == tgt)) begin
                    cap_o   = CHANS'(1) << s_d.slot;
                    first_o = (s_d.slot == '0);
                end
            end else begin
                chg = (fclk_i != s_q.fclk_last);
                if (chg) begin
                    s_d.cnt    = '0;
                    s_d.synced = 1'b1;
                end else if (s_q.cnt != '1) begin
                    s_d.cnt = s_q.cnt + CNT_W'(1);
                end
                if (is_rj) begin
                    // the half that just ended is named by the old level
                    left = s_q.fclk_last;
                    if (chg && s_q.synced) begin
                        cap_o   = left ? left_bits : right_bits;
                        first_o = left;
                    end
                end else begin
                    left = is_i2s ? ~fclk_i : fclk_i;
                    if ((chg || s_q.synced) && (s_d.cnt == tgt)) begin
                        cap_o   = left ? left_bits : right_bits;
                        first_o = left;
                    end
                end
            end
        end

        single_o = is_single;
        old_o    = is_rj;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.slot <= SLOT_END;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
    import sarx_pkg::*;
#(
    parameter int SLOT_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [2:0]                   fmt_i,
    input  logic [WL_W-1:0]              wlen_i,
    input  logic                         bclk_i,
    input  logic                         fclk_i,
    input  logic [LINES-1:0]             sd_i,
    output logic [CHANS-1:0][WORD_W-1:0] smp_o,
    output logic                         valid_o
);
    typedef struct packed {
        logic [CHANS-1:0][WORD_W-1:0] smp;
        logic [CHANS-1:0]             seen;
        logic                         valid;
    } out_st_t;

    out_st_t r_d, r_q;

    logic             bit_stb, fclk_s;
    logic [LINES-1:0] sd_s;
    logic [WL_W-1:0]  wl_eff;
    logic [CHANS-1:0] cap, upd;
    logic             first, single, old;
    word_t            words [LINES];

    always_comb begin
        if (wlen_i < WL_W'(MIN_W))       wl_eff = WL_W'(MIN_W);
        else if (wlen_i > WL_W'(WORD_W)) wl_eff = WL_W'(WORD_W);
        else                             wl_eff = wlen_i;
    end

    sarx_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .bclk_i    (bclk_i),
        .fclk_i    (fclk_i),
        .sd_i      (sd_i),
        .bit_stb_o (bit_stb),
        .fclk_o    (fclk_s),
        .sd_o      (sd_s)
    );

    sarx_frame #(.SLOT_W(SLOT_W), .CNT_W(CNT_W)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .fmt_i     (fmt_i),
        .wl_i      (wl_eff),
        .bit_stb_i (bit_stb),
        .fclk_i    (fclk_s),
        .cap_o     (cap),
        .first_o   (first),
        .single_o  (single),
        .old_o     (old)
    );

    for (genvar g = 0; g < LINES; g++) begin : g_line
        sarx_shift u_shift (
            .clk    (clk),
            .rst_n  (rst_n),
            .en_i   (bit_stb),
            .bit_i  (sd_s[g]),
            .old_i  (old),
            .wl_i   (wl_eff),
            .word_o (words[g])
        );
    end

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        for (int i = 0; i < CHANS; i++) begin
            if (cap[i]) r_d.smp[i] = single ? words[0] : words[i / 2];
        end
        upd = (first ? '0 : r_q.seen) | cap;
        if (cap != '0) begin
            if (&upd) begin
                r_d.valid = 1'b1;
                r_d.seen  = '0;
            end else begin
                r_d.seen = upd;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign smp_o   = r_q.smp;
    assign valid_o = r_q.valid;
endmodule

// File: rtl/sarx_checker.sv
module sarx_checker
    import sarx_pkg::*;
(
    input logic                         clk,
    input logic                         rst_n,
    input logic                         valid_o,
    input logic [CHANS-1:0][WORD_W-1:0] smp_o,
    input logic                         bit_stb,
    input logic [CHANS-1:0]             cap,
    input logic                         single,
    input logic [WL_W-1:0]              wl_eff
);
    logic pad_ok;

    always_comb begin
        pad_ok = 1'b1;
        for (int i = 0; i < CHANS; i++) begin
            if ((smp_o[i] << wl_eff) != '0) pad_ok = 1'b0;
        end
    end

    a_r10_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    a_r10_valid_after_bit: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(bit_stb));

    a_r11_hold_without_bit: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_stb |=> $stable(smp_o));

    a_r7_one_slot_per_bit: assert property (@(posedge clk) disable iff (!rst_n)
        single |-> $onehot0(cap));

    a_r6_stereo_pairs: assert property (@(posedge clk) disable iff (!rst_n)
        (!single && cap != '0) |-> (cap == {LINES{2'b01}} || cap == {LINES{2'b10}}));

    a_r9_zero_pad: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> pad_ok);
endmodule

bind serial_audio_rx sarx_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_o (valid_o),
    .smp_o   (smp_o),
    .bit_stb (bit_stb),
    .cap     (cap),
    .single  (single),
    .wl_eff  (wl_eff)
);

// File: tb/serial_audio_rx_test.sv
`timescale 1ns/1ps
module serial_audio_rx_test;
    import sarx_pkg::*;

    localparam int NF = 3;
    localparam int HB = 32;
    localparam int SW = 32;

    logic                         clk = 1'b0;
    logic                         rst_n = 1'b0;
    logic [2:0]                   fmt = 3'd0;
    logic [WL_W-1:0]              wlen = WL_W'(24);
    logic                         bclk = 1'b0;
    logic                         fclk = 1'b0;
    logic [LINES-1:0]             sd = '0;
    logic [CHANS-1:0][WORD_W-1:0] smp;
    logic                         valid;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    vcount = 0;
    int    vbase = 0;
    string cur_req = "R1";
    logic [23:0] exp_mem [NF][CHANS];
    logic [23:0] raw_mem [NF][CHANS];

    always #2 clk = ~clk;

    serial_audio_rx #(.SLOT_W(SW), .CNT_W(8)) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .fmt_i   (fmt),
        .wlen_i  (wlen),
        .bclk_i  (bclk),
        .fclk_i  (fclk),
        .sd_i    (sd),
        .smp_o   (smp),
        .valid_o (valid)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    function automatic int clamp_wl(input int w);
        if (w < 16) return 16;
        if (w > 24) return 24;
        return w;
    endfunction

    function automatic logic filler(input int j, input int l);
        return ((j * 5 + l * 3) % 7) < 3;
    endfunction

    function automatic logic [23:0] raw_word(input int f, input int ch, input int wl, input int fm);
        logic [31:0] v;
        logic [31:0] m;
        v = 32'h005A3C96 ^ (f * 32'h9E37 + ch * 32'h3B1D + wl * 32'h0101 + fm * 32'h7777);
        m = (32'h1 << wl) - 32'h1;
        return 24'(v & m);
    endfunction

    function automatic logic st_bit(input int fm, input int wl, input int j, input logic [23:0] w, input int l);
        if (fm == 2)      return (j >= HB - wl) ? w[HB - 1 - j] : filler(j, l);
        else if (fm == 1) return (j >= 1 && j <= wl) ? w[wl - j] : filler(j, l);
        else              return (j < wl) ? w[wl - 1 - j] : filler(j, l);
    endfunction

    // monitor: compare each frame strobe against the frame it closes
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && valid) begin
                if (vcount - vbase < NF) begin
                    for (int ch = 0; ch < CHANS; ch++)
                        check(smp[ch] == exp_mem[vcount - vbase][ch], cur_req,
                              32'(smp[ch]), 32'(exp_mem[vcount - vbase][ch]));
                end
                vcount++;
            end
        end
    end

    task automatic bit_out(input logic f, input logic [LINES-1:0] d);
        @(negedge clk);
        bclk = 1'b0;
        fclk = f;
        sd   = d;
        repeat (3) @(negedge clk);
        bclk = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic do_reset(input int fm, input int w);
        @(negedge clk);
        rst_n = 1'b0;
        bclk  = 1'b0;
        fclk  = 1'b0;
        sd    = '0;
        fmt   = 3'(fm);
        wlen  = WL_W'(w);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(valid === 1'b0 && smp === '0, "R1", {31'b0, valid} | (smp != '0 ? 32'h2 : 32'h0), 32'h0);
    endtask

    task automatic prep(input int fm, input int w);
        int wl;
        wl = clamp_wl(w);
        for (int f = 0; f < NF; f++)
            for (int ch = 0; ch < CHANS; ch++) begin
                raw_mem[f][ch] = raw_word(f, ch, wl, fm);
                exp_mem[f][ch] = raw_mem[f][ch] << (24 - wl);
            end
        vbase = vcount;
    endtask

    task automatic run_stereo(input int fm, input int w, input string req);
        int   wl;
        logic lv;
        logic [LINES-1:0] d;
        wl = clamp_wl(w);
        cur_req = (w != wl) ? {req, " R9"} : req;
        do_reset(fm, w);
        prep(fm, w);
        lv = (fm == 1) ? 1'b0 : 1'b1;
        for (int j = 0; j < HB; j++) begin
            for (int l = 0; l < LINES; l++) d[l] = filler(j, l);
            bit_out(~lv, d);
        end
        for (int f = 0; f < NF; f++)
            for (int h = 0; h < 2; h++)
                for (int j = 0; j < HB; j++) begin
                    for (int l = 0; l < LINES; l++)
                        d[l] = st_bit(fm, wl, j, raw_mem[f][2 * l + h], l);
                    bit_out(h == 0 ? lv : ~lv, d);
                end
        for (int j = 0; j < HB; j++) begin
            for (int l = 0; l < LINES; l++) d[l] = filler(j + 1, l);
            bit_out(lv, d);
        end
        repeat (4) @(negedge clk);
        check(vcount - vbase == NF, "R10 frame strobe count", 32'(vcount - vbase), 32'(NF));
    endtask

    task automatic run_single(input int fm, input int w);
        int   wl;
        int   dl;
        int   q;
        logic f_lv;
        logic [LINES-1:0] d;
        wl = clamp_wl(w);
        cur_req = (w != wl) ? "R7 R8 R9" : "R7 R8";
        do_reset(fm, w);
        prep(fm, w);
        dl = (fm == 4) ? 1 : 0;
        for (int f = 0; f < NF; f++)
            for (int p = 0; p < CHANS * SW; p++) begin
                q = p - dl;
                if (q >= 0 && (q % SW) < wl && (q / SW) < CHANS)
                    d[0] = raw_mem[f][q / SW][wl - 1 - (q % SW)];
                else
                    d[0] = filler(p, 0);
                d[1] = 1'($urandom);
                d[2] = 1'($urandom);
                f_lv = (fm == 4) ? (p == 0) : (p < CHANS * SW / 2);
                bit_out(f_lv, d);
            end
        for (int j = 0; j < 8; j++) bit_out(1'b0, 3'($urandom));
        repeat (4) @(negedge clk);
        check(vcount - vbase == NF, "R10 frame strobe count", 32'(vcount - vbase), 32'(NF));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog R10: run still busy, actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [CHANS-1:0][WORD_W-1:0] snap;
        int wls [4] = '{16, 20, 24, 10};
        for (int k = 0; k < 4; k++) begin
            run_stereo(0, wls[k], "R3 R6");
            run_stereo(1, wls[k], "R4 R6");
            run_stereo(2, wls[k], "R5 R6");
            run_stereo(5, wls[k], "R2 R3");
        end
        run_stereo(0, 31, "R3 R6");
        run_single(3, 16);
        run_single(3, 24);
        run_single(4, 16);
        run_single(4, 24);
        run_single(4, 30);
        run_single(3, 12);

        // R11: frame clock and data activity with the bit clock idle
        snap = smp;
        vbase = vcount;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            bclk = 1'b0;
            fclk = 1'(i % 3 == 0);
            sd   = 3'(i);
        end
        repeat (4) @(negedge clk);
        check(smp == snap, "R11 hold without bit clock", 32'(smp[0]), 32'(snap[0]));
        check(vcount == vbase, "R11 no strobe without bit clock", 32'(vcount - vbase), 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule